// File: doc/BRIEF.md
# Daisy-Chain Converter Frame Reader

This block is the host end of a chain of serial 16-bit analog-to-digital converters. The converters are connected output to input and share one conversion-start line, and no busy flag is used. A single-cycle start request begins a frame. The reader raises the conversion-start line while the serial clock is low and keeps the serial clock idle for a programmable conversion time. It then clocks out the whole chain, `WORD_W` × `N_DEV` bits, on the serial data line of the converter nearest the host.

Bits are captured on the rising serial-clock edge, halfway between the falling edges on which the converters shift. The reader rebuilds one word per converter and presents it with its chain position and a one-cycle valid strobe. When the last bit has been taken, it drops the conversion-start line and pulses frame-done. A programmable low time on the start line must pass before the reader accepts the next frame.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, and for as long as no start is requested, `convst_o` and `sclk_o` stay low and `word_vld_o` and `frame_done_o` stay low.
- R2: A start accepted in idle raises `convst_o` while `sclk_o` is low. `sclk_o` then stays low so that its first rising edge comes exactly `CONV_CYC` + `HALF_DIV` clocks after `convst_o` rises.
- R3: During the read, each high phase and each low phase of `sclk_o` lasts `HALF_DIV` clocks, and a frame has exactly `WORD_W` × `N_DEV` rising edges.
- R4: `sdo_i` is captured at each rising edge of `sclk_o`, and every word is assembled with its first captured bit as the MSB.
- R5: `word_idx_o` gives chain position, where 0 is the converter whose serial input is tied low (farthest from the host) and `N_DEV`-1 is the converter that drives `sdo_i`. The first word of a frame carries index `N_DEV`-1, and each later word carries an index one lower.
- R6: `word_vld_o` is a one-cycle pulse, given exactly `N_DEV` times per frame, with each word in `word_o` during its pulse.
- R7: `convst_o` stays high until the last falling edge of `sclk_o`, so its high time is `CONV_CYC` + 2·`HALF_DIV`·`WORD_W`·`N_DEV` clocks. `sclk_o` is never high while `convst_o` is low.
- R8: `frame_done_o` pulses once per frame, in the first cycle in which `convst_o` is low again, after every word of the frame has been presented.
- R9: After a frame, `convst_o` stays low for at least `IDLE_MIN` clocks. With start held high, the next rise comes exactly `IDLE_MIN`+1 clocks after the fall.
- R10: A start request during conversion, shifting or the post-frame low time is ignored. It adds no frame, and it does not change the running frame's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, sampled each clock |
| sdo_i | input | 1 | Serial data from the converter nearest the host |
| convst_o | output | 1 | Conversion start, held high for the whole frame |
| sclk_o | output | 1 | Serial clock to the chain |
| word_o | output | WORD_W | Assembled converter word |
| word_idx_o | output | IDX_W | Chain position of `word_o` |
| word_vld_o | output | 1 | One-cycle strobe for `word_o` and `word_idx_o` |
| frame_done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The hardest situation to reach from the ports is a start request that arrives while the reader is not idle. It has to be seen to have no effect, both inside a frame and in the short low window after one. The bench times start pulses against its own record of the conversion and clock edges, so that they land in the conversion wait, in the middle of the shift, and in the first cycle after frame-done. It then confirms that no extra conversion-start rise follows and that the frame timing and data are unchanged. A second run holds start permanently high across a frame boundary to measure the minimum low time exactly.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_REST  = 2'd3
  } seq_state_t;

  // counter width able to hold values 0..n-1, never zero
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/chain_sclk_gen.sv
module chain_sclk_gen
  import adc_chain_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned PW = cnt_w(HALF_DIV);

  logic [PW-1:0] ph_q, ph_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run_i && (ph_q == PW'(HALF_DIV - 1));

  always_comb begin
    ph_d   = ph_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      ph_d   = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      ph_d   = '0;
      sclk_d = ~sclk_q;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  // strobes mark the system edge at which the serial clock changes
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick &  sclk_q;
  assign sclk_o = sclk_q;

endmodule

// File: rtl/chain_deser.sv
module chain_deser
  import adc_chain_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_DEV  = 3,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              rise_i,
  input  logic              sdo_i,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              vld_o
);

  localparam int unsigned BW = cnt_w(WORD_W);

  logic [WORD_W-2:0] sh_q, sh_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [IDX_W-1:0]  nxt_idx_q, nxt_idx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              vld_q, vld_d;
  logic              word_end;
  logic              out_en;

  assign word_end = rise_i && (bit_q == BW'(WORD_W - 1));
  assign out_en   = word_end;

  always_comb begin
    sh_d      = sh_q;
    bit_d     = bit_q;
    nxt_idx_d = nxt_idx_q;
    word_d    = word_q;
    widx_d    = widx_q;
    vld_d     = 1'b0;
    if (clear_i) begin
      bit_d     = '0;
      nxt_idx_d = IDX_W'(N_DEV - 1);
    end else if (rise_i) begin
      sh_d = {sh_q[WORD_W-3:0], sdo_i};
      if (word_end) begin
        bit_d     = '0;
        word_d    = {sh_q, sdo_i};
        widx_d    = nxt_idx_q;
        vld_d     = 1'b1;
        nxt_idx_d = nxt_idx_q - 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      bit_q     <= '0;
      nxt_idx_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      sh_q      <= sh_d;
      bit_q     <= bit_d;
      nxt_idx_q <= nxt_idx_d;
      vld_q     <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      widx_q <= '0;
    end else if (out_en) begin
      word_q <= word_d;
      widx_q <= widx_d;
    end
  end

  assign word_o = word_q;
  assign idx_o  = widx_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/chain_seq.sv
module chain_seq
  import adc_chain_pkg::*;
#(
  parameter int unsigned CONV_CYC   = 20,
  parameter int unsigned IDLE_MIN   = 4,
  parameter int unsigned TOTAL_BITS = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic fall_i,
  output logic convst_o,
  output logic run_o,
  output logic clear_o,
  output logic done_o
);

  localparam int unsigned WW = cnt_w(max2(CONV_CYC, IDLE_MIN));
  localparam int unsigned FW = cnt_w(TOTAL_BITS);

  seq_state_t    st_q, st_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          cv_q, cv_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    wcnt_d = wcnt_q;
    fcnt_d = fcnt_q;
    cv_d   = cv_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_CONV;
          cv_d   = 1'b1;
          wcnt_d = '0;
          fcnt_d = '0;
        end
      end
      ST_CONV: begin
        if (wcnt_q == WW'(CONV_CYC - 1)) begin
          st_d = ST_SHIFT;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (fall_i) begin
          if (fcnt_q == FW'(TOTAL_BITS - 1)) begin
            st_d   = ST_REST;
            cv_d   = 1'b0;
            done_d = 1'b1;
            wcnt_d = '0;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      ST_REST: begin
        if (wcnt_q == WW'(IDLE_MIN - 1)) begin
          st_d = ST_IDLE;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      fcnt_q <= '0;
      cv_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      fcnt_q <= fcnt_d;
      cv_q   <= cv_d;
      done_q <= done_d;
    end
  end

  assign convst_o = cv_q;
  assign run_o    = (st_q == ST_SHIFT);
  assign clear_o  = (st_q == ST_IDLE);
  assign done_o   = done_q;

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
  import adc_chain_pkg::*;
#(
  parameter int unsigned N_DEV    = 3,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned CONV_CYC = 20,
  parameter int unsigned IDLE_MIN = 4,
  localparam int unsigned IDX_W   = cnt_w(N_DEV)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sdo_i,
  output logic              convst_o,
  output logic              sclk_o,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic              word_vld_o,
  output logic              frame_done_o
);

  localparam int unsigned TOTAL_BITS = WORD_W * N_DEV;

  logic run;
  logic clear;
  logic sclk_rise;
  logic sclk_fall;

  chain_seq #(
    .CONV_CYC  (CONV_CYC),
    .IDLE_MIN  (IDLE_MIN),
    .TOTAL_BITS(TOTAL_BITS)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .fall_i  (sclk_fall),
    .convst_o(convst_o),
    .run_o   (run),
    .clear_o (clear),
    .done_o  (frame_done_o)
  );

  chain_sclk_gen #(
    .HALF_DIV(HALF_DIV)
  ) u_sclk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (run),
    .sclk_o(sclk_o),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall)
  );

  chain_deser #(
    .WORD_W(WORD_W),
    .N_DEV (N_DEV),
    .IDX_W (IDX_W)
  ) u_deser (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(clear),
    .rise_i (sclk_rise),
    .sdo_i  (sdo_i),
    .word_o (word_o),
    .idx_o  (word_idx_o),
    .vld_o  (word_vld_o)
  );

endmodule

// File: rtl/adc_chain_reader_chk.sv
module adc_chain_reader_chk #(
  parameter int unsigned N_DEV    = 3,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned IDLE_MIN = 4,
  parameter int unsigned IDX_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             convst_o,
  input logic             sclk_o,
  input logic             word_vld_o,
  input logic [IDX_W-1:0] word_idx_o,
  input logic             frame_done_o
);

  logic [15:0] hi_run;
  logic [15:0] lo_run;
  logic        seen_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      seen_fall <= 1'b0;
    end else begin
      if (sclk_o) begin
        if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
      end
      if (!convst_o) begin
        if (lo_run != 16'hFFFF) lo_run <= lo_run + 1'b1;
      end else begin
        lo_run <= '0;
      end
      if (frame_done_o) seen_fall <= 1'b1;
    end
  end

  assert_sclk_low_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_o) |-> !sclk_o);

  assert_sclk_high_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (hi_run == 16'(HALF_DIV)));

  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> (word_idx_o < IDX_W'(N_DEV)));

  assert_vld_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  assert_sclk_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> convst_o);

  assert_done_at_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> (!convst_o && $past(convst_o)));

  assert_rest_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(convst_o) && seen_fall) |-> (lo_run >= 16'(IDLE_MIN)));

endmodule

bind adc_chain_reader adc_chain_reader_chk #(
  .N_DEV   (N_DEV),
  .HALF_DIV(HALF_DIV),
  .IDLE_MIN(IDLE_MIN),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .convst_o    (convst_o),
  .sclk_o      (sclk_o),
  .word_vld_o  (word_vld_o),
  .word_idx_o  (word_idx_o),
  .frame_done_o(frame_done_o)
);

// File: tb/test_adc_chain_reader.sv
`timescale 1ns/1ps
module test_adc_chain_reader;

  localparam int N_DEV    = 3;
  localparam int WORD_W   = 16;
  localparam int HALF_DIV = 2;
  localparam int CONV_CYC = 20;
  localparam int IDLE_MIN = 4;
  localparam int IDX_W    = 2;
  localparam int TOTAL    = WORD_W * N_DEV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              sdo_i;
  logic              convst_o;
  logic              sclk_o;
  logic [WORD_W-1:0] word_o;
  logic [IDX_W-1:0]  word_idx_o;
  logic              word_vld_o;
  logic              frame_done_o;

  always #4 clk = ~clk;

  adc_chain_reader #(
    .N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_DIV(HALF_DIV),
    .CONV_CYC(CONV_CYC), .IDLE_MIN(IDLE_MIN)
  ) i_adc_chain_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sdo_i(sdo_i),
    .convst_o(convst_o), .sclk_o(sclk_o), .word_o(word_o),
    .word_idx_o(word_idx_o), .word_vld_o(word_vld_o),
    .frame_done_o(frame_done_o)
  );

  // behavioural chain: device 0 is farthest, its serial input tied low
  logic [WORD_W-1:0] dev_val [N_DEV];
  logic [TOTAL-1:0]  chain_sr = '0;
  logic              m_cv = 1'b0;
  logic              m_sclk = 1'b0;

  always @(convst_o or sclk_o) begin
    if (convst_o && !m_cv) begin
      for (int d = 0; d < N_DEV; d++) chain_sr[d*WORD_W +: WORD_W] = dev_val[d];
    end else if (!sclk_o && m_sclk) begin
      chain_sr = {chain_sr[TOTAL-2:0], 1'b0};
    end
    m_cv   = convst_o;
    m_sclk = sclk_o;
  end
  assign sdo_i = chain_sr[TOTAL-1];

  int errors = 0;
  int checks = 0;

  // port monitor, sampled away from the active edge
  int cyc = 0;
  int t_cv_rise = 0, t_cv_fall = 0, t_first_rise = 0, t_last_rise = 0, t_last_fall = 0;
  int cv_rise_cnt = 0, rise_cnt = 0, phase_bad = 0, nwords = 0, done_cnt = 0, words_at_done = 0;
  int sclk_at_rise = 0, done_on_fall = 0, vld_long = 0;
  logic [WORD_W-1:0] got_w [8];
  int                got_i [8];
  logic p_cv = 1'b0, p_sclk = 1'b0, p_vld = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (convst_o && !p_cv) begin
      t_cv_rise = cyc; cv_rise_cnt++; sclk_at_rise = sclk_o;
      rise_cnt = 0; nwords = 0; phase_bad = 0; vld_long = 0;
    end
    if (!convst_o && p_cv) t_cv_fall = cyc;
    if (sclk_o && !p_sclk) begin
      if (rise_cnt == 0) t_first_rise = cyc;
      else if (cyc - t_last_fall != HALF_DIV) phase_bad++;
      rise_cnt++; t_last_rise = cyc;
    end
    if (!sclk_o && p_sclk) begin
      if (cyc - t_last_rise != HALF_DIV) phase_bad++;
      t_last_fall = cyc;
    end
    if (word_vld_o) begin
      if (p_vld) vld_long++;
      if (nwords < 8) begin got_w[nwords] = word_o; got_i[nwords] = int'(word_idx_o); end
      nwords++;
    end
    if (frame_done_o) begin
      done_cnt++; done_on_fall = (!convst_o && p_cv) ? 1 : 0; words_at_done = nwords;
    end
    p_cv = convst_o; p_sclk = sclk_o; p_vld = word_vld_o;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    int guard = 0;
    while (done_cnt < target && guard < 5000) begin @(negedge clk); guard++; end
  endtask

  task automatic frame_checks(input string tag);
    check_eq({tag, " R2 sclk low at convst rise"}, sclk_at_rise, 0);
    check_eq({tag, " R2 conversion wait"}, t_first_rise - t_cv_rise, CONV_CYC + HALF_DIV);
    check_eq({tag, " R3 rising edges"}, rise_cnt, TOTAL);
    check_eq({tag, " R3 phase widths"}, phase_bad, 0);
    check_eq({tag, " R6 word count"}, nwords, N_DEV);
    check_eq({tag, " R6 strobe width"}, vld_long, 0);
    for (int k = 0; k < N_DEV; k++) begin
      check_eq({tag, " R5 index order"}, got_i[k], N_DEV - 1 - k);
      check_eq({tag, " R4 word data"}, int'(got_w[k]), int'(dev_val[N_DEV - 1 - k]));
    end
    check_eq({tag, " R7 convst high time"}, t_cv_fall - t_cv_rise,
             CONV_CYC + 2 * HALF_DIV * TOTAL);
    check_eq({tag, " R8 done at convst fall"}, done_on_fall, 1);
    check_eq({tag, " R8 words before done"}, words_at_done, N_DEV);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check_eq("R1 convst in reset", int'(convst_o), 0);
    check_eq("R1 sclk in reset", int'(sclk_o), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R1 convst idle", int'(convst_o), 0);
    check_eq("R1 sclk idle", int'(sclk_o), 0);
    check_eq("R1 vld idle", int'(word_vld_o), 0);
    check_eq("R1 done idle", int'(frame_done_o), 0);
    check_eq("R1 no frame without start", cv_rise_cnt, 0);
  endtask

  task automatic t_frame(input string tag, input logic [WORD_W-1:0] v0,
                         input logic [WORD_W-1:0] v1, input logic [WORD_W-1:0] v2);
    int d0 = done_cnt;
    dev_val[0] = v0; dev_val[1] = v1; dev_val[2] = v2;
    pulse_start();
    wait_done(d0 + 1);
    frame_checks(tag);
    repeat (IDLE_MIN + 3) @(negedge clk);
  endtask

  task automatic t_busy_starts();
    int d0 = done_cnt;
    int r0 = cv_rise_cnt;
    dev_val[0] = 16'h0F0F; dev_val[1] = 16'h5A5A; dev_val[2] = 16'hC001;
    pulse_start();
    repeat (5) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;      // during conversion
    while (rise_cnt < 20) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;      // during shifting
    wait_done(d0 + 1);
    frame_checks("busy");
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;      // during post-frame low time
    repeat (40) @(negedge clk);
    check_eq("R10 no extra frame", cv_rise_cnt - r0, 1);
    check_eq("R10 single done", done_cnt - d0, 1);
    check_eq("R10 convst stays low", int'(convst_o), 0);
  endtask

  task automatic t_back_to_back();
    int d0 = done_cnt;
    int r0 = cv_rise_cnt;
    dev_val[0] = 16'h1357; dev_val[1] = 16'h2468; dev_val[2] = 16'h9ABC;
    @(negedge clk); start_i = 1'b1;
    wait_done(d0 + 1);
    frame_checks("held start 1");
    while (cv_rise_cnt < r0 + 2) @(negedge clk);
    check_eq("R9 min low time", t_cv_rise - t_cv_fall, IDLE_MIN + 1);
    start_i = 1'b0;
    wait_done(d0 + 2);
    frame_checks("held start 2");
    repeat (IDLE_MIN + 3) @(negedge clk);
  endtask

  initial begin
    for (int d = 0; d < N_DEV; d++) dev_val[d] = '0;
    t_reset();
    t_frame("pattern", 16'hA5C3, 16'h1234, 16'hFFFE);
    t_frame("extremes", 16'h0000, 16'hFFFF, 16'h8001);
    t_frame("walking", 16'h0001, 16'h0080, 16'h4000);
    t_busy_starts();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule